// File: doc/BRIEF.md
# SPI Word FIFO Pair with Event Interrupts

This block sits between a register port and the serial shift engine of an SPI controller. It holds the transmit and receive word queues and the status and interrupt logic that software uses to keep them serviced. Software writes outgoing words into the transmit queue through a data register. The shift engine takes them one per pop strobe. Received words arrive on a push strobe from the engine, and software drains them through a second data register. Each read of that register removes one word.

The transmit interrupt tracks queue emptiness, so software can refill the queue. The receive interrupt fires when the receive level has gone above a programmable threshold, or when the peripheral has been released. Each side keeps a flag register, which mixes live level bits with sticky event bits. Each side also has an enable register, and a write-one-to-clear register for the sticky bits. Software can flush either queue from the configuration register. A word-width field trims data to 8, 16, 24 or 32 bits on the register side.

Registers sit at byte offsets on a 6-bit address. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the current state, and a read of the receive data register pops at that edge.

Top module: `sfq_spi_fifo_irq`

## Requirements
- R1: After reset, both levels read 0. The transmit flag register (offset 0x08) reads 0x02 (empty only). The receive flag register (0x14) reads 0. Both enables read 0, both interrupt outputs are low, `tx_avail_o` is 0 and `rx_room_o` is 1.
- R2: Words written to the transmit data register (0x20) come out on `tx_word_o` in write order, one per `tx_pop_i`. Words pushed with `rx_push_i` are returned in push order by reads of the receive data register (0x24), and each such read removes one word.
- R3: The level register (0x04) holds the receive word count in bits 12:8 and the transmit word count in bits 20:16. Both counts are current one clock after the push or pop.
- R4: Each queue holds 16 words. A push to a full queue is dropped and leaves the count and the stored words unchanged. A pop or read from an empty queue leaves the count at 0.
- R5: The configuration register (0x00) holds the receive threshold in bits 3:0, the transmit threshold in bits 7:4 and the word width in bits 9:8. Writing 1 to bit 11 empties the receive queue, and writing 1 to bit 12 empties the transmit queue, both at that same edge. Bits 11 and 12 always read 0.
- R6: In the transmit flag register, bit 0 (full) and bit 1 (empty) follow the live queue level. Bit 6 latches a pulse on `slave_rel_i`.
- R7: In the receive flag register, bit 5 latches on the clock edge after the receive count first exceeds the threshold. Bit 6 latches a pulse on `slave_rel_i`. Both bits stay set after their cause has gone.
- R8: Writing 1s to the transmit clear register (0x10) or to the receive clear register (0x1C) clears the matching sticky bits. Live bits are not affected. Both clear registers read 0.
- R9: `tx_irq_o` is high exactly when the transmit flags AND the transmit enable register (0x0C) is nonzero. `rx_irq_o` is high exactly when the receive flags AND the receive enable register (0x18) is nonzero. Both enable registers read back.
- R10: The width code 0/1/2/3 selects 8/16/24/32 bits. Words written to the transmit data register are stored with the bits above the width forced to 0. Reads of the receive data register return 0 above the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops at the receive data offset) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| tx_pop_i | input | 1 | Shift engine takes the head transmit word |
| tx_word_o | output | 32 | Head of the transmit queue |
| tx_avail_o | output | 1 | Transmit queue holds at least one word |
| rx_push_i | input | 1 | Shift engine delivers a received word |
| rx_word_i | input | 32 | Received word |
| rx_room_o | output | 1 | Receive queue can accept a word |
| slave_rel_i | input | 1 | One-cycle pulse: peripheral released |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
Level counts, live full and empty bits, the transmit data head and the interrupt lines are due one edge after a push, pop, flush or enable write. The bench therefore samples them at the falling edge that follows the strobe's rising edge. The above-threshold bit is due one edge later still: the queue count must first register, and only then does the latch see it. The bench reads that flag once right after the push and expects 0, then reads it again and expects it set. Register read data is combinational, so each read is sampled 1 ns after the address is applied and well before the next rising edge.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 6;
   localparam int unsigned FLAG_W = 8;

   // register byte offsets
   localparam logic [ADDR_W-1:0] OFS_CFG    = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_LEVEL  = 6'h04;
   localparam logic [ADDR_W-1:0] OFS_TXFLAG = 6'h08;
   localparam logic [ADDR_W-1:0] OFS_TXEN   = 6'h0C;
   localparam logic [ADDR_W-1:0] OFS_TXCLR  = 6'h10;
   localparam logic [ADDR_W-1:0] OFS_RXFLAG = 6'h14;
   localparam logic [ADDR_W-1:0] OFS_RXEN   = 6'h18;
   localparam logic [ADDR_W-1:0] OFS_RXCLR  = 6'h1C;
   localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h20;
   localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h24;

   // configuration field positions
   localparam int unsigned CFG_RXTHR_LSB = 0;
   localparam int unsigned CFG_TXTHR_LSB = 4;
   localparam int unsigned CFG_WID_LSB   = 8;
   localparam int unsigned CFG_RXFLUSH   = 11;
   localparam int unsigned CFG_TXFLUSH   = 12;
   localparam int unsigned THR_W         = 4;

   // level field positions and width
   localparam int unsigned LVL_RX_LSB = 8;
   localparam int unsigned LVL_TX_LSB = 16;
   localparam int unsigned LVL_W      = 5;

   // flag bit positions
   localparam int unsigned FLG_FULL  = 0;
   localparam int unsigned FLG_EMPTY = 1;
   localparam int unsigned FLG_THR   = 5;
   localparam int unsigned FLG_REL   = 6;

   localparam logic [FLAG_W-1:0] TX_STICKY = 8'h40;
   localparam logic [FLAG_W-1:0] RX_STICKY = 8'h60;

   typedef enum logic [1:0] {
      WID_8  = 2'd0,
      WID_16 = 2'd1,
      WID_24 = 2'd2,
      WID_32 = 2'd3
   } word_wid_e;

   function automatic logic [REG_W-1:0] wid_mask(word_wid_e w);
      logic [REG_W-1:0] m;
      case (w)
         WID_8:   m = 32'h0000_00FF;
         WID_16:  m = 32'h0000_FFFF;
         WID_24:  m = 32'h00FF_FFFF;
         default: m = 32'hFFFF_FFFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              full_o,
   output logic              empty_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sfq_fifo: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("sfq_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_push, do_pop;

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wp_q] <= push_data_i;
   end

   assign head_o  = mem_q[rp_q];
   assign count_o = cnt_q;

   AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CNT_W'(DEPTH)); // R4
   AST_FULL_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && full_o && !pop_i && !flush_i) |=> (count_o == CNT_W'(DEPTH))); // R4
   AST_EMPTY_POP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && empty_o && !push_i && !flush_i) |=> empty_o); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (count_o == '0)); // R5

endmodule

// File: rtl/sfq_flags.sv
module sfq_flags #(
   parameter int unsigned         NBITS  = 8,
   parameter logic [NBITS-1:0]    STICKY = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NBITS-1:0] evt_i,
   input  logic             en_we_i,
   input  logic [NBITS-1:0] en_data_i,
   input  logic             clr_we_i,
   input  logic [NBITS-1:0] clr_data_i,
   output logic [NBITS-1:0] flag_o,
   output logic [NBITS-1:0] en_o,
   output logic             irq_o
);

   logic [NBITS-1:0] flag_w;
   logic [NBITS-1:0] en_q;
   logic             unused_clr;

   assign unused_clr = ^(clr_data_i & ~STICKY);

   // sticky bits latch their event, level bits mirror it
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      if (STICKY[b]) begin : g_sticky
         logic bit_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                         bit_q <= 1'b0;
            else if (evt_i[b])                   bit_q <= 1'b1;
            else if (clr_we_i && clr_data_i[b])  bit_q <= 1'b0;
         end
         assign flag_w[b] = bit_q;
      end else begin : g_level
         assign flag_w[b] = evt_i[b];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q <= '0;
      else if (en_we_i) en_q <= en_data_i;
   end

   assign flag_o = flag_w;
   assign en_o   = en_q;
   assign irq_o  = |(flag_w & en_q);

   AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_w & STICKY & ~({NBITS{clr_we_i}} & clr_data_i)) != '0)
      |=> ((flag_w & $past(flag_w & STICKY & ~({NBITS{clr_we_i}} & clr_data_i)))
           == $past(flag_w & STICKY & ~({NBITS{clr_we_i}} & clr_data_i)))); // R8
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (en_q != '0)); // R9

endmodule

// File: rtl/sfq_spi_fifo_irq.sv
module sfq_spi_fifo_irq
   import sfq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                reg_wr_i,
   input  logic                reg_rd_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [REG_W-1:0]    reg_wdata_i,
   output logic [REG_W-1:0]    reg_rdata_o,
   input  logic                tx_pop_i,
   output logic [DATA_W-1:0]   tx_word_o,
   output logic                tx_avail_o,
   input  logic                rx_push_i,
   input  logic [DATA_W-1:0]   rx_word_i,
   output logic                rx_room_o,
   input  logic                slave_rel_i,
   output logic                tx_irq_o,
   output logic                rx_irq_o
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("sfq_spi_fifo_irq: DATA_W must equal the register width");
      end
      if (CNT_W > LVL_W) begin : g_bad_level
         $error("sfq_spi_fifo_irq: DEPTH does not fit the level fields");
      end
   endgenerate

   // register decode
   logic wr_cfg, wr_txd, wr_txen, wr_txclr, wr_rxen, wr_rxclr, rd_rxd;
   assign wr_cfg   = reg_wr_i && (reg_addr_i == OFS_CFG);
   assign wr_txd   = reg_wr_i && (reg_addr_i == OFS_TXDATA);
   assign wr_txen  = reg_wr_i && (reg_addr_i == OFS_TXEN);
   assign wr_txclr = reg_wr_i && (reg_addr_i == OFS_TXCLR);
   assign wr_rxen  = reg_wr_i && (reg_addr_i == OFS_RXEN);
   assign wr_rxclr = reg_wr_i && (reg_addr_i == OFS_RXCLR);
   assign rd_rxd   = reg_rd_i && (reg_addr_i == OFS_RXDATA);

   // configuration
   logic [THR_W-1:0] rx_thr_q, tx_thr_q;
   word_wid_e        wid_q;
   logic             rx_flush, tx_flush;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_thr_q <= '0;
         tx_thr_q <= '0;
         wid_q    <= WID_32;
      end else if (wr_cfg) begin
         rx_thr_q <= reg_wdata_i[CFG_RXTHR_LSB +: THR_W];
         tx_thr_q <= reg_wdata_i[CFG_TXTHR_LSB +: THR_W];
         wid_q    <= word_wid_e'(reg_wdata_i[CFG_WID_LSB +: 2]);
      end
   end

   assign rx_flush = wr_cfg && reg_wdata_i[CFG_RXFLUSH];
   assign tx_flush = wr_cfg && reg_wdata_i[CFG_TXFLUSH];

   logic [DATA_W-1:0] act_mask;
   assign act_mask = wid_mask(wid_q);

   // queues
   logic [DATA_W-1:0] tx_head, rx_head;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;

   sfq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (tx_flush),
      .push_i      (wr_txd),
      .push_data_i (reg_wdata_i & act_mask),
      .pop_i       (tx_pop_i),
      .head_o      (tx_head),
      .count_o     (tx_cnt),
      .full_o      (tx_full),
      .empty_o     (tx_empty)
   );

   sfq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (rx_flush),
      .push_i      (rx_push_i),
      .push_data_i (rx_word_i),
      .pop_i       (rd_rxd),
      .head_o      (rx_head),
      .count_o     (rx_cnt),
      .full_o      (rx_full),
      .empty_o     (rx_empty)
   );

   assign tx_word_o  = tx_head;
   assign tx_avail_o = !tx_empty;
   assign rx_room_o  = !rx_full;

   // event sources
   logic [FLAG_W-1:0] tx_evt, rx_evt;
   logic              rx_over_thr;

   assign rx_over_thr = (rx_cnt > CNT_W'(rx_thr_q));

   always_comb begin
      tx_evt            = '0;
      tx_evt[FLG_FULL]  = tx_full;
      tx_evt[FLG_EMPTY] = tx_empty;
      tx_evt[FLG_REL]   = slave_rel_i;
      rx_evt            = '0;
      rx_evt[FLG_THR]   = rx_over_thr;
      rx_evt[FLG_REL]   = slave_rel_i;
   end

   logic [FLAG_W-1:0] tx_flag, tx_en, rx_flag, rx_en;

   sfq_flags #(.NBITS(FLAG_W), .STICKY(TX_STICKY)) u_txflg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (tx_evt),
      .en_we_i    (wr_txen),
      .en_data_i  (reg_wdata_i[FLAG_W-1:0]),
      .clr_we_i   (wr_txclr),
      .clr_data_i (reg_wdata_i[FLAG_W-1:0]),
      .flag_o     (tx_flag),
      .en_o       (tx_en),
      .irq_o      (tx_irq_o)
   );

   sfq_flags #(.NBITS(FLAG_W), .STICKY(RX_STICKY)) u_rxflg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (rx_evt),
      .en_we_i    (wr_rxen),
      .en_data_i  (reg_wdata_i[FLAG_W-1:0]),
      .clr_we_i   (wr_rxclr),
      .clr_data_i (reg_wdata_i[FLAG_W-1:0]),
      .flag_o     (rx_flag),
      .en_o       (rx_en),
      .irq_o      (rx_irq_o)
   );

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         OFS_CFG: begin
            reg_rdata_o[CFG_RXTHR_LSB +: THR_W] = rx_thr_q;
            reg_rdata_o[CFG_TXTHR_LSB +: THR_W] = tx_thr_q;
            reg_rdata_o[CFG_WID_LSB +: 2]       = wid_q;
         end
         OFS_LEVEL: begin
            reg_rdata_o[LVL_RX_LSB +: CNT_W] = rx_cnt;
            reg_rdata_o[LVL_TX_LSB +: CNT_W] = tx_cnt;
         end
         OFS_TXFLAG: reg_rdata_o[FLAG_W-1:0] = tx_flag;
         OFS_TXEN:   reg_rdata_o[FLAG_W-1:0] = tx_en;
         OFS_RXFLAG: reg_rdata_o[FLAG_W-1:0] = rx_flag;
         OFS_RXEN:   reg_rdata_o[FLAG_W-1:0] = rx_en;
         OFS_RXDATA: reg_rdata_o = rx_head & act_mask;
         default:    reg_rdata_o = '0;
      endcase
   end

   AST_RX_THR_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_over_thr |=> rx_flag[FLG_THR]); // R7
   AST_TX_EMPTY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_en[FLG_EMPTY] && !tx_avail_o) |-> tx_irq_o); // R9
   AST_RX_ROOM_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_push_i && !rx_room_o && !rd_rxd && !rx_flush) |=> !rx_room_o); // R4

endmodule

// File: tb/sim_sfq_spi_fifo_irq.sv
module sim_sfq_spi_fifo_irq;

   localparam logic [5:0] A_CFG = 6'h00, A_LVL = 6'h04, A_TXF = 6'h08, A_TXE = 6'h0C,
                          A_TXC = 6'h10, A_RXF = 6'h14, A_RXE = 6'h18, A_RXC = 6'h1C,
                          A_TXD = 6'h20, A_RXD = 6'h24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        tx_pop = 1'b0, tx_avail;
   logic [31:0] tx_word;
   logic        rx_push = 1'b0, rx_room;
   logic [31:0] rx_word = '0;
   logic        slave_rel = 1'b0;
   logic        tx_irq, rx_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [31:0] exp_tx[$];
   logic [31:0] exp_rx[$];
   logic [31:0] mask = 32'hFFFF_FFFF;

   always #10 clk = ~clk;

   sfq_spi_fifo_irq u0 (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
      .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .tx_pop_i(tx_pop), .tx_word_o(tx_word), .tx_avail_o(tx_avail),
      .rx_push_i(rx_push), .rx_word_i(rx_word), .rx_room_o(rx_room),
      .slave_rel_i(slave_rel), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [5:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [5:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic expect_reg(string req, logic [5:0] a, logic [31:0] e);
      logic [31:0] v;
      reg_read(a, v);
      check(req, v, e);
   endtask

   // driver: transmit word into the queue and the scoreboard
   task automatic tx_write(logic [31:0] d);
      if (exp_tx.size() < 16) exp_tx.push_back(d & mask);
      reg_write(A_TXD, d);
   endtask

   // monitor side of transmit: compare head before each pop
   task automatic tx_take(string req);
      if (exp_tx.size() > 0) begin
         logic [31:0] e;
         e = exp_tx.pop_front();
         check(req, {31'd0, tx_avail}, 32'd1);
         check(req, tx_word, e);
      end else begin
         check(req, {31'd0, tx_avail}, 32'd0);
      end
      tx_pop = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic rx_give(logic [31:0] d);
      if (exp_rx.size() < 16) exp_rx.push_back(d);
      rx_push = 1'b1; rx_word = d;
      @(posedge clk); @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic rx_take(string req);
      logic [31:0] v;
      logic [31:0] e;
      reg_read(A_RXD, v);
      if (exp_rx.size() > 0) begin
         e = exp_rx.pop_front();
         check(req, v, e & mask);
      end
   endtask

   function automatic logic [31:0] lvl(int rx, int tx);
      return (32'(rx) << 8) | (32'(tx) << 16);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_reg("R1 level", A_LVL, 32'h0);
      expect_reg("R1 txflag", A_TXF, 32'h02);
      expect_reg("R1 rxflag", A_RXF, 32'h00);
      expect_reg("R1 txen", A_TXE, 32'h0);
      expect_reg("R1 rxen", A_RXE, 32'h0);
      check("R1 irqs", {30'd0, tx_irq, rx_irq}, 32'd0);
      check("R1 avail/room", {30'd0, tx_avail, rx_room}, 32'd1);

      // R5 configuration read back: width 32, tx thr 5, rx thr 3
      reg_write(A_CFG, 32'h0000_0353);
      expect_reg("R5 cfg", A_CFG, 32'h0000_0353);

      // R2/R3 short transmit burst
      tx_write(32'h1111_0001);
      tx_write(32'h2222_0002);
      tx_write(32'h3333_0003);
      expect_reg("R3 tx level", A_LVL, lvl(0, 3));
      for (int i = 0; i < 3; i++) tx_take("R2 tx order");
      expect_reg("R3 tx level drained", A_LVL, lvl(0, 0));

      // R4/R6 transmit fill to full plus one extra
      for (int i = 0; i < 17; i++) tx_write(32'hC000_0000 + 32'(i));
      expect_reg("R4 tx level capped", A_LVL, lvl(0, 16));
      expect_reg("R6 tx full flag", A_TXF, 32'h01);
      for (int i = 0; i < 16; i++) tx_take("R4 tx contents kept");
      tx_take("R4 pop empty");
      expect_reg("R4 tx level after empty pop", A_LVL, lvl(0, 0));
      expect_reg("R6 tx empty flag", A_TXF, 32'h02);

      // R9 transmit interrupt on empty
      reg_write(A_TXE, 32'h02);
      expect_reg("R9 txen readback", A_TXE, 32'h02);
      check("R9 tx irq empty", {31'd0, tx_irq}, 32'd1);
      tx_write(32'h0000_ABCD);
      check("R9 tx irq cleared by data", {31'd0, tx_irq}, 32'd0);
      tx_take("R2 single");
      check("R9 tx irq again", {31'd0, tx_irq}, 32'd1);
      reg_write(A_TXE, 32'h00);
      check("R9 tx irq masked", {31'd0, tx_irq}, 32'd0);

      // R7 receive threshold (3): 3 words do not exceed, the 4th does
      for (int i = 0; i < 3; i++) rx_give(32'hA000_0000 + 32'(i));
      expect_reg("R7 at threshold", A_RXF, 32'h00);
      rx_give(32'hA000_0003);
      expect_reg("R7 one edge late", A_RXF, 32'h00);
      expect_reg("R7 latched", A_RXF, 32'h20);
      expect_reg("R3 rx level", A_LVL, lvl(4, 0));
      for (int i = 0; i < 4; i++) rx_take("R2 rx order");
      expect_reg("R7 sticky after drain", A_RXF, 32'h20);
      reg_write(A_RXE, 32'h20);
      check("R9 rx irq", {31'd0, rx_irq}, 32'd1);
      reg_write(A_RXC, 32'hFFFF_FFFF);
      expect_reg("R8 rx cleared", A_RXF, 32'h00);
      check("R8 rx irq drops", {31'd0, rx_irq}, 32'd0);
      expect_reg("R8 rxclr reads 0", A_RXC, 32'h0);

      // R6/R7/R8/R9 slave release
      slave_rel = 1'b1;
      @(posedge clk); @(negedge clk);
      slave_rel = 1'b0;
      expect_reg("R6 tx release", A_TXF, 32'h42);
      expect_reg("R7 rx release", A_RXF, 32'h40);
      check("R9 rx irq masked bit", {31'd0, rx_irq}, 32'd0);
      reg_write(A_RXC, 32'h40);
      expect_reg("R8 rx release cleared", A_RXF, 32'h00);
      reg_write(A_TXC, 32'hFFFF_FFFF);
      expect_reg("R8 live empty kept", A_TXF, 32'h02);
      expect_reg("R8 txclr reads 0", A_TXC, 32'h0);
      reg_write(A_RXE, 32'h00);

      // R4 receive overflow
      for (int i = 0; i < 17; i++) rx_give(32'h5000_0000 + 32'(i));
      expect_reg("R4 rx level capped", A_LVL, lvl(16, 0));
      check("R4 rx room", {31'd0, rx_room}, 32'd0);
      for (int i = 0; i < 16; i++) rx_take("R4 rx contents kept");
      rx_take("R4 read empty");
      expect_reg("R4 rx level after empty read", A_LVL, lvl(0, 0));
      reg_write(A_RXC, 32'hFFFF_FFFF);

      // R5 flush both queues
      for (int i = 0; i < 5; i++) rx_give(32'h7700_0000 + 32'(i));
      for (int i = 0; i < 3; i++) tx_write(32'h6600_0000 + 32'(i));
      expect_reg("R3 both levels", A_LVL, lvl(5, 3));
      reg_write(A_CFG, 32'h0000_1B53);
      exp_rx.delete();
      exp_tx.delete();
      expect_reg("R5 flushed", A_LVL, lvl(0, 0));
      expect_reg("R5 flush bits read 0", A_CFG, 32'h0000_0353);
      rx_give(32'h1234_5678);
      rx_take("R5 clean after flush");
      reg_write(A_RXC, 32'hFFFF_FFFF);

      // R10 word width
      reg_write(A_CFG, 32'h0000_0053);
      mask = 32'h0000_00FF;
      tx_write(32'hA5A5_1234);
      tx_take("R10 tx 8-bit");
      reg_write(A_CFG, 32'h0000_0153);
      mask = 32'h0000_FFFF;
      rx_give(32'hDEAD_BEEF);
      rx_take("R10 rx 16-bit");
      reg_write(A_CFG, 32'h0000_0253);
      mask = 32'h00FF_FFFF;
      rx_give(32'hDEAD_BEEF);
      rx_take("R10 rx 24-bit");
      tx_write(32'hFEDC_BA98);
      tx_take("R10 tx 24-bit");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule